// File: doc/BRIEF.md
# SYSREF Pulse-Select Initializer

This block decides which rising edge of a sampled SYSREF level may reset a clocked sub-block. It holds two selector channels. The divider channel serves a clock divider: its pulse count restarts whenever software writes a new value into its 3-bit mode field. The link channel serves a link logic core: its pulse count restarts when the link-init control fields finish a fixed three-step sequence. Each channel drives a one-cycle initialization strobe. A channel can pass every edge, exactly the first, second or third edge after a restart, or no edge at all. Once a single-edge channel has fired, it ignores all later edges until its next restart. This lets SYSREF stay active for other users, or be switched off, without re-initializing a block that is already running.

SYSREF enters through a two-flop synchronizer and a rising-edge detector, so each strobe follows the qualifying edge by a fixed latency. After the link channel fires, the block pulls its active-low sync-request output low. The request stays low while the link-init fields remain in the run setting.

Mode codes (3 bits, the same for both channels): 3'b001 passes every edge; 3'b010 passes only the first edge; 3'b011 only the second; 3'b101 only the third; 3'b000 and every other code pass none.

Link-init steps, applied with the 4-bit state field and the core-reset flag:
- hold: state 4'b1111 with the flag 0.
- release: state 4'b1111 with the flag 1.
- run: state 4'b0000 with the flag 1.

State machines:
- Sequencer (`sr_link_seq`) has four states: SQ_IDLE, SQ_HOLD, SQ_REL and SQ_RUN.
  - Any state goes to SQ_HOLD on the hold step.
  - SQ_HOLD goes to SQ_REL on the release step.
  - SQ_REL goes to SQ_RUN on the run step, and that transition emits a start pulse.
  - SQ_REL and SQ_RUN stay where they are while their own step is held.
  - Any other input goes to SQ_IDLE.
- Selector (`sr_pulse_pick`) has three states: PK_IDLE, PK_WAIT and PK_SPENT.
  - A restart goes to PK_WAIT with the count cleared.
  - In PK_WAIT, an edge in every-edge mode fires and stays. In single-edge modes an edge is counted, and the edge that reaches the selected number fires and goes to PK_SPENT.
  - PK_SPENT ignores all edges.
  - Dropping the enable goes to PK_IDLE.

Top module: `sysref_pulse_select`

## Requirements
- R1: With mode 3'b001, the channel emits one strobe for every SYSREF rising edge after its restart.
- R2: With mode 3'b010, 3'b011 or 3'b101, the channel emits exactly one strobe, on the first, second or third rising edge after its restart respectively.
- R3: Mode 3'b000, and the unused codes 3'b100, 3'b110 and 3'b111, never produce a strobe.
- R4: The link channel counts edges only after the steps hold (4'b1111, flag 0), release (4'b1111, flag 1) and run (4'b0000, flag 1) occur in that order. Edges before the run step are ignored. Leaving the run setting disarms the channel.
- R5: After a single-edge channel has fired, later edges produce no strobe until the channel restarts.
- R6: A divider mode write whose value differs from the held value restarts the divider count. A write of the same value does not. An edge in the same cycle as a restarting write is not counted.
- R7: Each strobe is one cycle wide. It is high in the third clock cycle after the first rising clock edge that samples SYSREF high.
- R8: The active-low sync request goes low in the cycle after the link strobe and stays low while the run setting is held. It returns high when the link-init fields leave the run setting.
- R9: After reset, both strobes are low, the sync request is high, and the divider channel fires for no edge until a mode write changes its mode.
- R10: A link mode write does not restart the link count; the new code applies to the edges that follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Device-side clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sysref_i | input | 1 | SYSREF level, source-synchronous to clk_i |
| div_mode_i | input | 3 | Mode code for the divider channel |
| div_mode_we_i | input | 1 | Write strobe for div_mode_i |
| lnk_mode_i | input | 3 | Mode code for the link channel |
| lnk_mode_we_i | input | 1 | Write strobe for lnk_mode_i |
| lnk_state_i | input | 4 | Link-init state field |
| lnk_core_rst_ni | input | 1 | Link-init core reset flag (1 = released) |
| div_init_o | output | 1 | One-cycle divider initialization strobe |
| lnk_init_o | output | 1 | One-cycle link initialization strobe |
| lnk_sync_no | output | 1 | Active-low sync request of the link |

## Verification
A wrong count or a wrong selector state shows up at the strobe ports within one SYSREF pulse: a strobe appears on the wrong edge, appears twice, or does not appear. A broken edge path shows up as a strobe that lands off the fixed three-cycle latency. A sequencer that accepts a shortened or reordered init sequence shows up as a link strobe, and a sync request going low, for an edge that should have been ignored. The bench sweeps all eight mode codes on both channels over five pulses each, and also covers restart by repeated and coincident writes, a link mode change in mid-count, and leaving the run setting.

// File: rtl/sr_sel_pkg.sv
package sr_sel_pkg;

    localparam int SEL_MODE_W  = 3;
    localparam int SEL_MAX_NTH = 3;
    localparam int SEL_CNT_W   = $clog2(SEL_MAX_NTH + 1);

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_EVERY,
        SEL_NTH
    } sel_kind_e;

    typedef struct packed {
        sel_kind_e              kind;
        logic [SEL_CNT_W-1:0]   nth;
    } sel_dec_t;

    typedef enum logic [1:0] {
        PK_IDLE,
        PK_WAIT,
        PK_SPENT
    } pick_state_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_HOLD,
        SQ_REL,
        SQ_RUN
    } seq_state_e;

    // Mode code to selection: 001 every edge, 010/011/101 first/second/third edge.
    function automatic sel_dec_t sel_decode(input logic [SEL_MODE_W-1:0] code);
        sel_dec_t d;
        d.kind = SEL_NONE;
        d.nth  = '0;
        unique case (code)
            3'b001: d.kind = SEL_EVERY;
            3'b010: begin d.kind = SEL_NTH; d.nth = SEL_CNT_W'(1); end
            3'b011: begin d.kind = SEL_NTH; d.nth = SEL_CNT_W'(2); end
            3'b101: begin d.kind = SEL_NTH; d.nth = SEL_CNT_W'(3); end
            default: d.kind = SEL_NONE;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/sr_sync_edge.sv
module sr_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic level_i,
    output logic rise_o
);
    logic [STAGES-1:0] pipe_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) pipe_q <= '0;
                else         pipe_q <= level_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) pipe_q <= '0;
                else         pipe_q <= {pipe_q[STAGES-2:0], level_i};
            end
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= pipe_q[STAGES-1];
    end

    assign rise_o = pipe_q[STAGES-1] & ~prev_q;

    // R7: a detected edge lasts one cycle
    p_edge_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o);

endmodule

// File: rtl/sr_link_seq.sv
module sr_link_seq
    import sr_sel_pkg::*;
#(
    parameter int STATE_W = 4
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [STATE_W-1:0] state_i,
    input  logic               core_rst_ni,
    output logic               run_o,
    output logic               start_o
);
    localparam logic [STATE_W-1:0] HOLD_CODE = '1;
    localparam logic [STATE_W-1:0] RUN_CODE  = '0;

    seq_state_e st_q, st_d;
    logic       start_q;
    logic       step_hold, step_rel, step_run;

    assign step_hold = (state_i == HOLD_CODE) && !core_rst_ni;
    assign step_rel  = (state_i == HOLD_CODE) &&  core_rst_ni;
    assign step_run  = (state_i == RUN_CODE)  &&  core_rst_ni;

    always_comb begin
        st_d = SQ_IDLE;
        if (step_hold) begin
            st_d = SQ_HOLD;
        end else begin
            unique case (st_q)
                SQ_IDLE: st_d = SQ_IDLE;
                SQ_HOLD: st_d = step_rel ? SQ_REL : SQ_IDLE;
                SQ_REL:  st_d = step_rel ? SQ_REL : (step_run ? SQ_RUN : SQ_IDLE);
                SQ_RUN:  st_d = step_run ? SQ_RUN : SQ_IDLE;
                default: st_d = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= SQ_IDLE;
        else         st_q <= st_d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) start_q <= 1'b0;
        else         start_q <= (st_q == SQ_REL) && (st_d == SQ_RUN);
    end

    assign run_o   = (st_q == SQ_RUN);
    assign start_o = start_q;

    // R4: run is only entered from the release step
    p_run_order_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(run_o) |-> ($past(st_q) == SQ_REL));

    // R4: the start pulse coincides with the first run cycle
    p_start_in_run_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_o |-> (run_o && $rose(run_o)));

endmodule

// File: rtl/sr_pulse_pick.sv
module sr_pulse_pick
    import sr_sel_pkg::*;
(
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  enable_i,
    input  logic                  restart_i,
    input  logic                  edge_i,
    input  logic [SEL_MODE_W-1:0] mode_i,
    output logic                  fire_o
);
    localparam logic [SEL_CNT_W-1:0] CNT_MAX = '1;

    pick_state_e          st_q, st_d;
    logic [SEL_CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
    logic                 fire_q, fire_d;
    sel_dec_t             dec;

    assign dec     = sel_decode(mode_i);
    assign cnt_inc = cnt_q + SEL_CNT_W'(1);

    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        fire_d = 1'b0;
        if (!enable_i) begin
            st_d  = PK_IDLE;
            cnt_d = '0;
        end else if (restart_i) begin
            st_d  = PK_WAIT;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                PK_IDLE:  st_d = PK_IDLE;
                PK_WAIT: begin
                    if (edge_i) begin
                        unique case (dec.kind)
                            SEL_EVERY: fire_d = 1'b1;
                            SEL_NTH: begin
                                if (cnt_q != CNT_MAX) cnt_d = cnt_inc;
                                if (cnt_inc == dec.nth) begin
                                    fire_d = 1'b1;
                                    st_d   = PK_SPENT;
                                end
                            end
                            default: fire_d = 1'b0;
                        endcase
                    end
                end
                PK_SPENT: st_d = PK_SPENT;
                default:  st_d = PK_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q  <= PK_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) fire_q <= 1'b0;
        else         fire_q <= fire_d;
    end

    assign fire_o = fire_q;

    // R7: a strobe follows an edge seen one cycle earlier
    p_fire_after_edge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fire_o |-> $past(edge_i));

    // R5: a spent selector stays silent
    p_spent_silent_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == PK_SPENT) |=> !fire_o);

    // R6: an edge in a restart cycle is not used
    p_restart_drops_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_i |=> !fire_o);

    // R3: codes outside the passing set never fire
    p_off_silent_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dec.kind == SEL_NONE) |=> !fire_o);

    // R7: strobes are one cycle wide outside every-edge mode
    p_fire_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fire_o && dec.kind != SEL_EVERY) |=> !fire_o);

endmodule

// File: rtl/sysref_pulse_select.sv
module sysref_pulse_select
    import sr_sel_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int STATE_W     = 4
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  sysref_i,
    input  logic [SEL_MODE_W-1:0] div_mode_i,
    input  logic                  div_mode_we_i,
    input  logic [SEL_MODE_W-1:0] lnk_mode_i,
    input  logic                  lnk_mode_we_i,
    input  logic [STATE_W-1:0]    lnk_state_i,
    input  logic                  lnk_core_rst_ni,
    output logic                  div_init_o,
    output logic                  lnk_init_o,
    output logic                  lnk_sync_no
);
    logic                  sr_rise;
    logic [SEL_MODE_W-1:0] div_mode_q, lnk_mode_q;
    logic                  div_restart;
    logic                  lnk_run, lnk_start;
    logic                  div_fire, lnk_fire;
    logic                  sync_n_q;

    sr_sync_edge #(.STAGES(SYNC_STAGES)) i_edge (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .level_i (sysref_i),
        .rise_o  (sr_rise)
    );

    assign div_restart = div_mode_we_i && (div_mode_i != div_mode_q);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            div_mode_q <= '0;
            lnk_mode_q <= '0;
        end else begin
            if (div_mode_we_i) div_mode_q <= div_mode_i;
            if (lnk_mode_we_i) lnk_mode_q <= lnk_mode_i;
        end
    end

    sr_link_seq #(.STATE_W(STATE_W)) i_seq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .state_i     (lnk_state_i),
        .core_rst_ni (lnk_core_rst_ni),
        .run_o       (lnk_run),
        .start_o     (lnk_start)
    );

    sr_pulse_pick i_div_pick (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .enable_i  (1'b1),
        .restart_i (div_restart),
        .edge_i    (sr_rise),
        .mode_i    (div_mode_q),
        .fire_o    (div_fire)
    );

    sr_pulse_pick i_lnk_pick (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .enable_i  (lnk_run),
        .restart_i (lnk_start),
        .edge_i    (sr_rise),
        .mode_i    (lnk_mode_q),
        .fire_o    (lnk_fire)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       sync_n_q <= 1'b1;
        else if (!lnk_run) sync_n_q <= 1'b1;
        else if (lnk_fire) sync_n_q <= 1'b0;
    end

    assign div_init_o  = div_fire;
    assign lnk_init_o  = lnk_fire;
    assign lnk_sync_no = sync_n_q;

    // R8: a link strobe inside the run setting lowers the sync request
    p_sync_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lnk_init_o && lnk_run) |=> !lnk_sync_no);

    // R8: the request is high whenever the link is out of the run setting
    p_sync_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lnk_run |=> lnk_sync_no);

    // R4: no link strobe without the run setting one cycle earlier
    p_link_needs_run_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lnk_init_o |-> $past(lnk_run));

endmodule

// File: tb/test_sysref_pulse_select.sv
`timescale 1ns/1ps
module test_sysref_pulse_select;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sysref = 1'b0;
    logic [2:0] div_mode = '0;
    logic       div_we = 1'b0;
    logic [2:0] lnk_mode = '0;
    logic       lnk_we = 1'b0;
    logic [3:0] lnk_state = '0;
    logic       lnk_crst_n = 1'b0;
    logic       div_init, lnk_init, sync_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sysref_pulse_select i_sysref_pulse_select (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .sysref_i        (sysref),
        .div_mode_i      (div_mode),
        .div_mode_we_i   (div_we),
        .lnk_mode_i      (lnk_mode),
        .lnk_mode_we_i   (lnk_we),
        .lnk_state_i     (lnk_state),
        .lnk_core_rst_ni (lnk_crst_n),
        .div_init_o      (div_init),
        .lnk_init_o      (lnk_init),
        .lnk_sync_no     (sync_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Strobes expected for the idx-th edge after a restart, from the mode codes
    function automatic int exp_fire(input int mode, input int idx);
        case (mode)
            1: return 1;
            2: return (idx == 1) ? 1 : 0;
            3: return (idx == 2) ? 1 : 0;
            5: return (idx == 3) ? 1 : 0;
            default: return 0;
        endcase
    endfunction

    task automatic wr_div(input logic [2:0] m);
        @(negedge clk); div_mode = m; div_we = 1'b1;
        @(negedge clk); div_we = 1'b0;
    endtask

    task automatic wr_lnk(input logic [2:0] m);
        @(negedge clk); lnk_mode = m; lnk_we = 1'b1;
        @(negedge clk); lnk_we = 1'b0;
    endtask

    task automatic set_init(input logic [3:0] st, input logic rn);
        @(negedge clk); lnk_state = st; lnk_crst_n = rn;
        @(negedge clk);
    endtask

    task automatic full_seq();
        set_init(4'b1111, 1'b0);
        set_init(4'b1111, 1'b1);
        set_init(4'b0000, 1'b1);
    endtask

    // One SYSREF pulse; optional divider write in the cycle the edge is used
    task automatic pulse(input bit mid_wr, input logic [2:0] m,
                         output int dcnt, output int dk,
                         output int lcnt, output int lk, output int syn);
        dcnt = 0; dk = 0; lcnt = 0; lk = 0;
        @(negedge clk); sysref = 1'b1;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            if (div_init) begin dcnt++; if (dk == 0) dk = k; end
            if (lnk_init) begin lcnt++; if (lk == 0) lk = k; end
            if (k == 4) sysref = 1'b0;
            if (k == 2 && mid_wr) begin div_mode = m; div_we = 1'b1; end
            if (k == 3) div_we = 1'b0;
        end
        syn = int'(sync_n);
    endtask

    initial begin
        int dc, dk, lc, lk, sy, fired;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 div strobe after reset", int'(div_init), 0);
        chk("R9 link strobe after reset", int'(lnk_init), 0);
        chk("R9 sync request after reset", int'(sync_n), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        pulse(1'b0, 3'b000, dc, dk, lc, lk, sy);
        chk("R9 divider idle before first mode change", dc, 0);
        chk("R4 link idle without init sequence", lc, 0);

        // Divider sweep: R1 R2 R3 R5 R7
        for (int m = 0; m < 8; m++) begin
            wr_div(3'(m) ^ 3'b100);
            wr_div(3'(m));
            for (int p = 1; p <= 5; p++) begin
                pulse(1'b0, 3'b000, dc, dk, lc, lk, sy);
                chk($sformatf("R2/R1/R3/R5 div mode %0d pulse %0d", m, p), dc, exp_fire(m, p));
                if (dc != 0) chk($sformatf("R7 div latency mode %0d", m), dk, 3);
                chk("R4 link silent during divider sweep", lc, 0);
            end
        end

        // R6 same-value write does not restart
        wr_div(3'b010);
        pulse(1'b0, 3'b000, dc, dk, lc, lk, sy);
        chk("R6 fresh first-pulse mode", dc, 1);
        wr_div(3'b010);
        pulse(1'b0, 3'b000, dc, dk, lc, lk, sy);
        chk("R6 same-value write keeps spent state", dc, 0);
        // R6 coincident write: edge dropped, next edge is the first
        wr_div(3'b011);
        pulse(1'b1, 3'b010, dc, dk, lc, lk, sy);
        chk("R6 edge coincident with write not counted", dc, 0);
        pulse(1'b0, 3'b000, dc, dk, lc, lk, sy);
        chk("R6 first edge after coincident write fires", dc, 1);
        wr_div(3'b000);

        // R4 incomplete sequences
        wr_lnk(3'b010);
        set_init(4'b0000, 1'b1);
        pulse(1'b0, 3'b000, dc, dk, lc, lk, sy);
        chk("R4 run step alone does not arm", lc, 0);
        set_init(4'b1111, 1'b0);
        set_init(4'b0000, 1'b1);
        pulse(1'b0, 3'b000, dc, dk, lc, lk, sy);
        chk("R4 skipped release step does not arm", lc, 0);
        chk("R8 sync high while unarmed", sy, 1);

        // Link sweep after full sequence: R1 R2 R3 R5 R7 R8
        for (int m = 0; m < 8; m++) begin
            set_init(4'b1111, 1'b0);
            wr_lnk(3'(m));
            set_init(4'b1111, 1'b1);
            set_init(4'b0000, 1'b1);
            fired = 0;
            for (int p = 1; p <= 5; p++) begin
                pulse(1'b0, 3'b000, dc, dk, lc, lk, sy);
                chk($sformatf("R2/R1/R3/R5 link mode %0d pulse %0d", m, p), lc, exp_fire(m, p));
                if (lc != 0) begin
                    chk($sformatf("R7 link latency mode %0d", m), lk, 3);
                    fired = 1;
                end
                chk($sformatf("R8 sync mode %0d pulse %0d", m, p), sy, fired != 0 ? 0 : 1);
                chk("R6 divider silent in mode 000", dc, 0);
            end
        end

        // R8 leaving run releases the request and disarms (R4)
        set_init(4'b1111, 1'b0);
        chk("R8 sync high after leaving run", int'(sync_n), 1);
        wr_lnk(3'b001);
        pulse(1'b0, 3'b000, dc, dk, lc, lk, sy);
        chk("R4 edges ignored out of run", lc, 0);

        // R10 link mode write mid-count does not restart
        wr_lnk(3'b101);
        set_init(4'b1111, 1'b1);
        set_init(4'b0000, 1'b1);
        pulse(1'b0, 3'b000, dc, dk, lc, lk, sy);
        chk("R10 first edge under third-pulse mode", lc, 0);
        wr_lnk(3'b011);
        pulse(1'b0, 3'b000, dc, dk, lc, lk, sy);
        chk("R10 second edge fires after live change", lc, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule